// File: doc/BRIEF.md
# Short Backward Branch Loop Buffer Controller

This block sits beside the fetch stage and watches the stream of fetch addresses and resolved branches. When a branch is taken backwards to a target close enough that the whole loop body fits in a small word buffer, the controller starts recording. Each word fetched from the instruction cache between the loop target and the branch is written into the buffer at the slot given by its distance from the target. Once that same branch is taken a second time, the loop body is complete in the buffer. From then on, fetches inside the loop are served from the buffer and the cache can stay idle.

Addresses are counted in whole instruction words, so consecutive fetches differ by one. The stored words are opaque: a packed word that carries several short instructions is recorded and replayed like any other. The controller returns to normal cache fetch when the captured branch falls through, when any other transfer is taken, or when the fetch address leaves the recorded range. The block's output tells the fetch stage, in the same cycle, whether to take the buffered word or the cache word.

Top module: `loopbuf_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, `mode` is 2'b00 (inactive), `useBuffer` is 0 and `bufWord` is 0. A range captured before reset is never used again afterwards.
- R2: In inactive mode, a branch (`isBranch`=1, `brTaken`=1) whose target satisfies `brTarget` <= `fetchPc` and `fetchPc` - `brTarget` <= DEPTH-1 moves `mode` to 2'b01 (fill) at the next clock. A target equal to the branch address also qualifies.
- R3: In inactive mode, `mode` stays 2'b00 in three cases: a taken branch whose span is DEPTH or more, a taken branch whose target is forward, and `brTaken` raised while `isBranch` is 0.
- R4: In fill mode, `useBuffer` is 0, and the word on `fetchWord` at each address from the target to the branch is stored at slot (`fetchPc` - target).
- R5: In fill mode, when the captured branch address is fetched with `isBranch`=1 and `brTaken`=1, `mode` becomes 2'b10 (active) at the next clock.
- R6: In active mode, with `fetchPc` inside [target, branch], `useBuffer` is 1 and `bufWord` equals the stored word for that address in the same cycle. The value on `fetchWord` has no effect.
- R7: In fill or active mode, when the captured branch is fetched with `isBranch`=1 and `brTaken`=0, `mode` returns to 2'b00 at the next clock.
- R8: In fill or active mode, any taken branch at an address other than the captured branch returns `mode` to 2'b00 at the next clock.
- R9: In active mode, a `fetchPc` outside the captured range gives `useBuffer`=0 and `bufWord`=0 in the same cycle, and `mode` returns to 2'b00 at the next clock.
- R10: In active mode, the captured branch taken again keeps `mode` at 2'b10.
- R11: `mode` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchPc | input | PC_W | Word address of the current fetch |
| fetchWord | input | WORD_W | Word returned by the instruction cache for `fetchPc` |
| isBranch | input | 1 | The word at `fetchPc` is a branch or jump |
| brTaken | input | 1 | That transfer is taken |
| brTarget | input | PC_W | Word address the transfer goes to |
| useBuffer | output | 1 | 1: fetch stage takes `bufWord` instead of the cache word |
| bufWord | output | WORD_W | Buffered word for `fetchPc`, zero when not supplying |
| mode | output | 2 | 00 inactive, 01 fill, 10 active |

## Verification
The hardest situation to reach from the ports is an active loop that ends because the fetch address leaves the recorded range without any branch being taken. A real pipeline never produces this, so the stimulus has to bring the controller to active first and then present an address just past the captured branch. The bench also builds a one-word loop, where the capture, the fill write and the activating branch all fall on the same address. It builds a loop whose span is exactly DEPTH-1 next to one that is one word longer, so both edges of the qualification check are exercised.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_FILL = 2'b01,
    MODE_RUN  = 2'b10
  } lbMode_e;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic capture; // latch loop target and branch address
    logic write;   // store fetchWord at the current slot
    logic read;    // drive the stored word to the output
  } lbStrobe_t;
endpackage

// File: rtl/lb_datapath.sv
module lb_datapath
  import lb_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic [PC_W-1:0]   brTarget,
  input  lbStrobe_t         stb,
  output logic              inRange,
  output logic              atBranch,
  output logic              qualify,
  output logic [WORD_W-1:0] bufWord
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PC_W-1:0] SPAN_LIMIT = PC_W'(DEPTH);

  logic [PC_W-1:0]   loopStart;
  logic [PC_W-1:0]   loopEnd;
  logic [PC_W-1:0]   offset;
  logic [IDX_W-1:0]  slot;
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loopStart <= '0;
      loopEnd   <= '0;
    end else if (stb.capture) begin
      loopStart <= brTarget;
      loopEnd   <= fetchPc;
    end
  end

  always_comb begin
    offset   = fetchPc - loopStart;
    slot     = offset[IDX_W-1:0];
    inRange  = (fetchPc >= loopStart) && (fetchPc <= loopEnd);
    atBranch = (fetchPc == loopEnd);
    qualify  = (brTarget <= fetchPc) && ((fetchPc - brTarget) < SPAN_LIMIT);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (stb.write && (slot == IDX_W'(e)))
        store[e] <= fetchWord;
    end
  end

  assign bufWord = stb.read ? store[slot] : '0;
endmodule

// File: rtl/lb_control.sv
module lb_control
  import lb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      isBranch,
  input  logic      brTaken,
  input  logic      inRange,
  input  logic      atBranch,
  input  logic      qualify,
  output lbStrobe_t stb,
  output lbMode_e   mode,
  output logic      useBuffer
);
  lbMode_e modeNext;

  always_comb begin
    modeNext    = mode;
    stb         = '0;
    unique case (mode)
      MODE_IDLE: begin
        if (isBranch && brTaken && qualify) begin
          modeNext    = MODE_FILL;
          stb.capture = 1'b1;
        end
      end
      MODE_FILL, MODE_RUN: begin
        stb.write = (mode == MODE_FILL) && inRange;
        stb.read  = (mode == MODE_RUN) && inRange;
        if (isBranch && atBranch)
          modeNext = brTaken ? MODE_RUN : MODE_IDLE;
        else if (isBranch && brTaken)
          modeNext = MODE_IDLE;
        else if (!inRange)
          modeNext = MODE_IDLE;
      end
      default: modeNext = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= MODE_IDLE;
    else        mode <= modeNext;
  end

  assign useBuffer = stb.read;
endmodule

// File: rtl/loopbuf_ctl.sv
module loopbuf_ctl
  import lb_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic              isBranch,
  input  logic              brTaken,
  input  logic [PC_W-1:0]   brTarget,
  output logic              useBuffer,
  output logic [WORD_W-1:0] bufWord,
  output logic [1:0]        mode
);
  lbStrobe_t stb;
  lbMode_e   modeState;
  logic      inRange, atBranch, qualify;

  lb_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .isBranch(isBranch), .brTaken(brTaken),
    .inRange(inRange), .atBranch(atBranch), .qualify(qualify),
    .stb(stb), .mode(modeState), .useBuffer(useBuffer)
  );

  lb_datapath #(.PC_W(PC_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .fetchPc(fetchPc), .fetchWord(fetchWord),
    .brTarget(brTarget), .stb(stb), .inRange(inRange), .atBranch(atBranch),
    .qualify(qualify), .bufWord(bufWord)
  );

  assign mode = modeState;
endmodule

// File: rtl/loopbuf_ctl_chk.sv
module loopbuf_ctl_chk #(
  parameter int PC_W   = 32,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   fetchPc,
  input logic              isBranch,
  input logic              brTaken,
  input logic [PC_W-1:0]   brTarget,
  input logic              useBuffer,
  input logic [WORD_W-1:0] bufWord,
  input logic [1:0]        mode
);
  logic shortBack;
  logic takenXfer;
  assign shortBack = (brTarget <= fetchPc) && ((fetchPc - brTarget) < PC_W'(DEPTH));
  assign takenXfer = isBranch && brTaken;

  AST_RESET_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mode == 2'b00); // R1
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> (!useBuffer && bufWord == '0)); // R1
  AST_ENTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && takenXfer && shortBack) |=> mode == 2'b01); // R2
  AST_STAY_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !(takenXfer && shortBack)) |=> mode == 2'b00); // R3
  AST_FILL_FROM_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |-> !useBuffer); // R4
  AST_ACTIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) != 2'b10) |-> ($past(mode) == 2'b01 && $past(takenXfer))); // R5
  AST_FORWARD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && takenXfer && brTarget > fetchPc) |=> mode == 2'b00); // R8
  AST_MISS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !useBuffer) |=> mode == 2'b00); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11); // R11
endmodule

bind loopbuf_ctl loopbuf_ctl_chk #(.PC_W(PC_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetchPc(fetchPc), .isBranch(isBranch),
  .brTaken(brTaken), .brTarget(brTarget), .useBuffer(useBuffer),
  .bufWord(bufWord), .mode(mode)
);

// File: tb/tb_loopbuf_ctl.sv
module tb_loopbuf_ctl;
  localparam int PC_W = 32;
  localparam int WORD_W = 32;
  localparam int DEPTH = 8;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] word;
    logic        isBr;
    logic        tk;
    logic [31:0] tgt;
    logic        expUse;
    logic [31:0] expWord;
    logic [1:0]  expMode;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 56;
  localparam logic [31:0] JNK = 32'hDEAD_BEEF;
  // expected values are those seen before the clock edge that follows the vector
  localparam vec_t VEC [NV] = '{
    '{32'd96,  32'hA0, 1'b0, 1'b0, 32'd0,   1'b0, 32'h0, 2'b00, 4'd1},  // R1 idle
    '{32'd120, 32'hA1, 1'b1, 1'b1, 32'd110, 1'b0, 32'h0, 2'b00, 4'd3},  // R3 span 10
    '{32'd110, 32'hA2, 1'b0, 1'b1, 32'd100, 1'b0, 32'h0, 2'b00, 4'd3},  // R3 not a branch
    '{32'd111, 32'hA3, 1'b1, 1'b1, 32'd130, 1'b0, 32'h0, 2'b00, 4'd3},  // R3 forward
    '{32'd103, 32'hA4, 1'b1, 1'b1, 32'd100, 1'b0, 32'h0, 2'b00, 4'd2},  // R2 qualifies
    '{32'd100, 32'h1000_0000, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4}, // R4
    '{32'd101, 32'h1000_0001, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd102, 32'h1000_0002, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd103, 32'h1000_0003, 1'b1, 1'b1, 32'd100, 1'b0, 32'h0, 2'b01, 4'd5}, // R5
    '{32'd100, JNK, 1'b0, 1'b0, 32'd0,   1'b1, 32'h1000_0000, 2'b10, 4'd6}, // R6
    '{32'd101, JNK, 1'b0, 1'b0, 32'd0,   1'b1, 32'h1000_0001, 2'b10, 4'd6},
    '{32'd102, JNK, 1'b0, 1'b0, 32'd0,   1'b1, 32'h1000_0002, 2'b10, 4'd6},
    '{32'd103, JNK, 1'b1, 1'b1, 32'd100, 1'b1, 32'h1000_0003, 2'b10, 4'd10}, // R10
    '{32'd100, JNK, 1'b0, 1'b0, 32'd0,   1'b1, 32'h1000_0000, 2'b10, 4'd10},
    '{32'd101, JNK, 1'b0, 1'b0, 32'd0,   1'b1, 32'h1000_0001, 2'b10, 4'd6},
    '{32'd102, JNK, 1'b0, 1'b0, 32'd0,   1'b1, 32'h1000_0002, 2'b10, 4'd6},
    '{32'd103, JNK, 1'b1, 1'b0, 32'd100, 1'b1, 32'h1000_0003, 2'b10, 4'd7}, // R7
    '{32'd104, 32'hA5, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b00, 4'd7},
    '{32'd207, 32'hB0, 1'b1, 1'b1, 32'd200, 1'b0, 32'h0, 2'b00, 4'd2}, // R2 span 7
    '{32'd200, 32'h2000_0000, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd201, 32'h2000_0001, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd202, 32'h2000_0002, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd203, 32'h2000_0003, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd204, 32'h2000_0004, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd205, 32'h2000_0005, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd206, 32'h2000_0006, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd207, 32'h2000_0007, 1'b1, 1'b1, 32'd200, 1'b0, 32'h0, 2'b01, 4'd5},
    '{32'd200, JNK, 1'b0, 1'b0, 32'd0,   1'b1, 32'h2000_0000, 2'b10, 4'd6},
    '{32'd207, JNK, 1'b0, 1'b0, 32'd0,   1'b1, 32'h2000_0007, 2'b10, 4'd6},
    '{32'd201, JNK, 1'b1, 1'b1, 32'd250, 1'b1, 32'h2000_0001, 2'b10, 4'd8}, // R8 active
    '{32'd250, 32'hB1, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b00, 4'd8},
    '{32'd305, 32'hC0, 1'b1, 1'b1, 32'd300, 1'b0, 32'h0, 2'b00, 4'd2},
    '{32'd300, 32'hC1, 1'b0, 1'b0, 32'd0,   1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd301, 32'hC2, 1'b1, 1'b1, 32'd330, 1'b0, 32'h0, 2'b01, 4'd8}, // R8 fill
    '{32'd330, 32'hC3, 1'b0, 1'b0, 32'd0,   1'b0, 32'h0, 2'b00, 4'd8},
    '{32'd405, 32'hD0, 1'b1, 1'b1, 32'd402, 1'b0, 32'h0, 2'b00, 4'd2},
    '{32'd402, 32'hD1, 1'b0, 1'b0, 32'd0,   1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd403, 32'hD2, 1'b0, 1'b0, 32'd0,   1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd404, 32'hD3, 1'b0, 1'b0, 32'd0,   1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd405, 32'hD4, 1'b1, 1'b0, 32'd402, 1'b0, 32'h0, 2'b01, 4'd7}, // R7 fill
    '{32'd406, 32'hD5, 1'b0, 1'b0, 32'd0,   1'b0, 32'h0, 2'b00, 4'd7},
    '{32'd503, 32'hE0, 1'b1, 1'b1, 32'd500, 1'b0, 32'h0, 2'b00, 4'd2},
    '{32'd500, 32'h3000_0000, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd501, 32'h3000_0001, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd502, 32'h3000_0002, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b01, 4'd4},
    '{32'd503, 32'h3000_0003, 1'b1, 1'b1, 32'd500, 1'b0, 32'h0, 2'b01, 4'd5},
    '{32'd500, JNK, 1'b0, 1'b0, 32'd0, 1'b1, 32'h3000_0000, 2'b10, 4'd6},
    '{32'd504, JNK, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b10, 4'd9}, // R9 outside range
    '{32'd505, 32'hE1, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b00, 4'd9},
    '{32'd608, 32'hF0, 1'b1, 1'b1, 32'd600, 1'b0, 32'h0, 2'b00, 4'd3}, // R3 span 8
    '{32'd600, 32'hF1, 1'b0, 1'b0, 32'd0,   1'b0, 32'h0, 2'b00, 4'd3},
    '{32'd700, 32'hF2, 1'b1, 1'b1, 32'd700, 1'b0, 32'h0, 2'b00, 4'd2}, // R2 span 0
    '{32'd700, 32'h4000_0000, 1'b1, 1'b1, 32'd700, 1'b0, 32'h0, 2'b01, 4'd5},
    '{32'd700, JNK, 1'b1, 1'b1, 32'd700, 1'b1, 32'h4000_0000, 2'b10, 4'd10},
    '{32'd701, JNK, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b10, 4'd9},
    '{32'd702, 32'hF3, 1'b0, 1'b0, 32'd0, 1'b0, 32'h0, 2'b00, 4'd9}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PC_W-1:0]   fetchPc = '0;
  logic [WORD_W-1:0] fetchWord = '0;
  logic              isBranch = 1'b0;
  logic              brTaken = 1'b0;
  logic [PC_W-1:0]   brTarget = '0;
  logic              useBuffer;
  logic [WORD_W-1:0] bufWord;
  logic [1:0]        mode;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  loopbuf_ctl #(.PC_W(PC_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .fetchPc(fetchPc), .fetchWord(fetchWord),
    .isBranch(isBranch), .brTaken(brTaken), .brTarget(brTarget),
    .useBuffer(useBuffer), .bufWord(bufWord), .mode(mode)
  );

  task automatic drive(input logic [31:0] pc, input logic [31:0] w,
                       input logic br, input logic tk, input logic [31:0] tg);
    @(negedge clk);
    fetchPc = pc; fetchWord = w; isBranch = br; brTaken = tk; brTarget = tg;
    #1;
  endtask

  task automatic check(input string tag, input logic eUse,
                       input logic [31:0] eWord, input logic [1:0] eMode);
    checks++;
    if (useBuffer !== eUse || bufWord !== eWord || mode !== eMode) begin
      fails++;
      $display("FAIL %s: got use=%0b word=%h mode=%b, expected use=%0b word=%h mode=%b",
               tag, useBuffer, bufWord, mode, eUse, eWord, eMode);
    end
  endtask

  initial begin
    #(4 * 5000);
    fails++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    drive(32'd0, 32'h0, 1'b1, 1'b1, 32'd0);
    check("R1 reset held", 1'b0, 32'h0, 2'b00);
    drive(32'd0, 32'h0, 1'b0, 1'b0, 32'd0);
    rst_n = 1'b1;
    check("R1 after release", 1'b0, 32'h0, 2'b00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].pc, VEC[i].word, VEC[i].isBr, VEC[i].tk, VEC[i].tgt);
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            VEC[i].expUse, VEC[i].expWord, VEC[i].expMode);
    end

    // R1: reset while active, then the old range must not supply words
    drive(32'd801, 32'h5000_0001, 1'b1, 1'b1, 32'd800);
    drive(32'd800, 32'h5000_0000, 1'b0, 1'b0, 32'd0);
    drive(32'd801, 32'h5000_0001, 1'b1, 1'b1, 32'd800);
    drive(32'd800, JNK, 1'b0, 1'b0, 32'd0);
    check("R6 before reset", 1'b1, 32'h5000_0000, 2'b10);
    rst_n = 1'b0;
    drive(32'd800, JNK, 1'b0, 1'b0, 32'd0);
    check("R1 reset from active", 1'b0, 32'h0, 2'b00);
    rst_n = 1'b1;
    drive(32'd800, JNK, 1'b0, 1'b0, 32'd0);
    check("R1 old range unused", 1'b0, 32'h0, 2'b00);
    drive(32'd801, JNK, 1'b0, 1'b0, 32'd0);
    check("R1 r1_still idle", 1'b0, 32'h0, 2'b00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule